// File: doc/BRIEF.md
# Toggle-Request Word Memory with Sequencing Controller

This block pairs a single-port, word-addressed memory with the small state machine that drives it. The controller runs on the rising clock edge and presents a registered request to the memory: a request bit, a write select, a word address and write data. A new request is signalled by inverting the request bit, not by holding a level. The memory runs on the falling clock edge. It keeps its own acknowledge bit. When that bit differs from the request bit, it performs exactly one access and then copies the request bit, so it turns itself off again before the next rising edge.

A user issues operations through a simple command port. A store is accepted in one cycle and the command port stays ready. A load is accepted in one cycle and occupies the controller for one more cycle, in which the value the memory placed on its read bus is captured. The captured word then appears on `rd_data` together with a one-cycle `rd_valid` pulse. Since the memory serves a request within the same clock period in which it was raised, a store followed at once by a load of the same word returns the freshly written value.

Top module: `tram_top`

## Requirements
- R1: After reset `op_ready` is 1, `rd_valid` is 0, `rd_data` is 0 and `ram_busy` is 0. With `CLEAR_ON_RST`=1 every word reads back as 0.
- R2: When `op_start`=1 and `op_write`=1 are sampled at a rising edge while `op_ready`=1, `op_wdata` is stored into word `op_addr`, and `op_ready` stays 1 in the next cycle.
- R3: When `op_start`=1 and `op_write`=0 are sampled at a rising edge while `op_ready`=1, `op_ready` is 0 for the next cycle only. In the cycle after that, `rd_valid` is 1 for exactly one cycle and `rd_data` holds the word at `op_addr`.
- R4: A store accepted in one cycle, followed by a load of the same address accepted in the very next cycle, returns the newly stored value.
- R5: Cycles with `op_start`=0 change no memory word, keep `rd_valid` at 0 and keep `rd_data` unchanged.
- R6: `ram_busy` is 1 between the rising edge that accepts an operation and the next falling edge, and is 0 whenever a rising edge arrives.
- R7: `op_start` is ignored while `op_ready` is 0. A store presented in that cycle writes nothing.
- R8: `rd_data` keeps its last load result through any number of stores and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The controller uses the rising edge and the memory uses the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Operation request, sampled at the rising edge |
| op_write | input | 1 | 1 = store, 0 = load |
| op_addr | input | $clog2(DEPTH) | Word address |
| op_wdata | input | DATA_W | Store data |
| op_ready | output | 1 | Controller can accept an operation |
| rd_valid | output | 1 | One-cycle pulse marking a completed load |
| rd_data | output | DATA_W | Result of the most recent load |
| ram_busy | output | 1 | Request bit and acknowledge bit differ |

## Verification
A memory acknowledge bit that fails to follow the request bit shows up on `ram_busy` at the very next rising edge. It also shifts the request phase, so a later store is dropped or a later load returns stale data. That error appears in `rd_data` two edges after the affected load is accepted. A wrong address, or a read port that is updated on a store, shows up as a mismatch on the first load of the affected word. The bench therefore writes and reads every word in several patterns, and it checks `ram_busy` on both sides of each accepting edge.

// File: rtl/tram_pkg.sv
package tram_pkg;
   typedef enum logic {
      CTL_IDLE = 1'b0,
      CTL_TAKE = 1'b1
   } ctl_state_t;
endpackage

// File: rtl/tram_core.sv
// Falling-edge memory. It serves one access whenever ack_q differs from
// req_bit, then copies req_bit so that it is idle again.
module tram_core #(
   parameter int DATA_W       = 32,
   parameter int DEPTH        = 256,
   parameter bit CLEAR_ON_RST = 1'b1,
   localparam int AW          = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_bit,
   input  logic              wsel,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack_q,
   output logic [DATA_W-1:0] rbus
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic              pending;

   always_comb pending = (ack_q != req_bit);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         rbus  <= '0;
      end else if (pending) begin
         ack_q <= req_bit;
         if (!wsel) rbus <= mem[waddr];
      end
   end

   generate
      if (CLEAR_ON_RST) begin : g_clear
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (pending && wsel) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(negedge clk) begin
            if (pending && wsel) mem[waddr] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/tram_ctrl.sv
// Rising-edge sequencer. A store is issued in one state. A load adds a
// capture state in which the memory's read bus is taken.
module tram_ctrl
   import tram_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_write,
   input  logic [AW-1:0]     op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   input  logic [DATA_W-1:0] rbus,
   output logic              req_bit,
   output logic              wsel,
   output logic [AW-1:0]     waddr,
   output logic [DATA_W-1:0] wdata,
   output logic              op_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   ctl_state_t state_q;

   always_comb op_ready = (state_q == CTL_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CTL_IDLE;
         req_bit  <= 1'b0;
         wsel     <= 1'b0;
         waddr    <= '0;
         wdata    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         unique case (state_q)
            CTL_IDLE: begin
               if (op_start) begin
                  req_bit <= ~req_bit;
                  wsel    <= op_write;
                  waddr   <= op_addr;
                  if (op_write) wdata <= op_wdata;
                  state_q <= op_write ? CTL_IDLE : CTL_TAKE;
               end
            end
            CTL_TAKE: begin
               rd_data  <= rbus;
               rd_valid <= 1'b1;
               state_q  <= CTL_IDLE;
            end
            default: state_q <= CTL_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tram_top.sv
module tram_top #(
   parameter int DATA_W       = 32,
   parameter int DEPTH        = 256,
   parameter bit CLEAR_ON_RST = 1'b1,
   localparam int AW          = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_write,
   input  logic [AW-1:0]     op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   output logic              op_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              ram_busy
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("tram_top: DATA_W must be at least 1");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("tram_top: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic              req_bit;
   logic              wsel;
   logic [AW-1:0]     waddr;
   logic [DATA_W-1:0] wdata;
   logic              ack_q;
   logic [DATA_W-1:0] rbus;

   tram_ctrl #(.DATA_W(DATA_W), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .op_start(op_start), .op_write(op_write),
      .op_addr(op_addr), .op_wdata(op_wdata),
      .rbus(rbus),
      .req_bit(req_bit), .wsel(wsel), .waddr(waddr), .wdata(wdata),
      .op_ready(op_ready), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   tram_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLEAR_ON_RST(CLEAR_ON_RST)) u_core (
      .clk(clk), .rst_n(rst_n),
      .req_bit(req_bit), .wsel(wsel), .waddr(waddr), .wdata(wdata),
      .ack_q(ack_q), .rbus(rbus)
   );

   always_comb ram_busy = ack_q ^ req_bit;
endmodule

// File: rtl/tram_chk.sv
module tram_chk #(
   parameter int DATA_W = 32,
   parameter int AW     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_start,
   input logic              op_write,
   input logic              op_ready,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              ram_busy
);
   // R6: the memory is idle whenever a rising edge arrives
   a_r6_idle_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_busy);

   // R2: a store keeps the command port ready
   a_r2_store_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && op_write && op_ready) |=> op_ready);

   // R3: a load blocks for one cycle, then produces a result pulse
   a_r3_load_sequence: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !op_write && op_ready) |=> (!op_ready && !rd_valid) ##1 (op_ready && rd_valid));

   // R3: the result pulse lasts a single cycle
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R8: the load result holds unless a new one is delivered
   a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> $stable(rd_data));

   // R7: the controller is never busy two cycles in a row
   a_r7_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !op_ready |=> op_ready);
endmodule

bind tram_top tram_chk #(.DATA_W(DATA_W), .AW(AW)) u_tram_chk (
   .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_write(op_write),
   .op_ready(op_ready), .rd_valid(rd_valid), .rd_data(rd_data),
   .ram_busy(ram_busy)
);

// File: tb/test_tram_top.sv
`timescale 1ns/1ps
module test_tram_top;
   localparam int W  = 8;
   localparam int D  = 16;
   localparam int AW = $clog2(D);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_start = 1'b0;
   logic          op_write = 1'b0;
   logic [AW-1:0] op_addr = '0;
   logic [W-1:0]  op_wdata = '0;
   logic          op_ready;
   logic          rd_valid;
   logic [W-1:0]  rd_data;
   logic          ram_busy;

   int errors = 0;
   int checks = 0;
   logic [W-1:0] model [D];
   logic [W-1:0] last_rd;

   always #2.5 clk = ~clk;

   tram_top #(.DATA_W(W), .DEPTH(D), .CLEAR_ON_RST(1'b1)) i_tram_top (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_write(op_write),
      .op_addr(op_addr), .op_wdata(op_wdata), .op_ready(op_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .ram_busy(ram_busy)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Sample point: 1 ns after a falling edge, well before the next rising edge.
   task automatic to_sample();
      @(negedge clk);
      #1;
   endtask

   task automatic do_store(input int a, input int d);
      chk("R2", "ready before store", int'(op_ready), 1);
      op_start = 1'b1; op_write = 1'b1; op_addr = AW'(a); op_wdata = W'(d);
      @(posedge clk); #1;
      chk("R6", "busy after store request", int'(ram_busy), 1);
      @(negedge clk); #1;
      op_start = 1'b0;
      chk("R6", "idle after store", int'(ram_busy), 0);
      chk("R2", "ready after store", int'(op_ready), 1);
      model[a] = W'(d);
   endtask

   task automatic do_load(input int a, input string req);
      op_start = 1'b1; op_write = 1'b0; op_addr = AW'(a);
      @(posedge clk); #1;
      chk("R6", "busy after load request", int'(ram_busy), 1);
      @(negedge clk); #1;
      op_start = 1'b0;
      chk("R3", "ready low in capture cycle", int'(op_ready), 0);
      chk("R3", "no pulse in capture cycle", int'(rd_valid), 0);
      to_sample();
      chk("R3", "pulse after capture", int'(rd_valid), 1);
      chk(req, "load data", int'(rd_data), int'(model[a]));
      chk("R6", "idle before edge", int'(ram_busy), 0);
      last_rd = model[a];
   endtask

   initial begin
      #(5.0 * 50000);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < D; i++) model[i] = '0;
      last_rd = '0;
      repeat (3) @(negedge clk);
      #1;
      // R1: state held in reset
      chk("R1", "ready in reset", int'(op_ready), 1);
      chk("R1", "valid in reset", int'(rd_valid), 0);
      chk("R1", "data in reset", int'(rd_data), 0);
      chk("R1", "busy in reset", int'(ram_busy), 0);
      rst_n = 1'b1;
      to_sample();
      chk("R1", "ready after reset", int'(op_ready), 1);
      // R1: cleared contents
      for (int a = 0; a < D; a++) do_load(a, "R1");

      // R2 then R3: sweep every word with an arithmetic pattern
      for (int a = 0; a < D; a++) do_store(a, (a * 37 + 5) % 256);
      for (int a = D - 1; a >= 0; a--) do_load(a, "R3");

      // R4: a store followed at once by a load of the same word
      for (int a = 0; a < D; a++) begin
         do_store(a, 255 - a * 11);
         do_load(a, "R4");
      end

      // R8: the load result holds across stores and idle cycles
      do_load(3, "R3");
      for (int a = 0; a < D; a += 2) begin
         do_store(a, a ^ 8'h5a);
         chk("R8", "result held over store", int'(rd_data), int'(last_rd));
      end

      // R5: idle cycles change nothing
      for (int k = 0; k < 10; k++) begin
         op_addr = AW'(k); op_wdata = 8'hff; op_write = 1'b1;
         to_sample();
         chk("R5", "no pulse when idle", int'(rd_valid), 0);
         chk("R5", "result held when idle", int'(rd_data), int'(last_rd));
         chk("R6", "idle when no request", int'(ram_busy), 0);
      end
      for (int a = 0; a < D; a++) do_load(a, "R5");

      // R7: a store presented while the controller is capturing is dropped
      for (int b = 0; b < D; b += 3) begin
         op_start = 1'b1; op_write = 1'b0; op_addr = AW'((b + 1) % D);
         to_sample();
         chk("R7", "busy capture cycle", int'(op_ready), 0);
         op_start = 1'b1; op_write = 1'b1; op_addr = AW'(b); op_wdata = 8'hc3;
         to_sample();
         op_start = 1'b0;
         chk("R3", "pulse for first load", int'(rd_valid), 1);
         chk("R3", "first load data", int'(rd_data), int'(model[(b + 1) % D]));
         chk("R7", "no new request", int'(ram_busy), 0);
         do_load(b, "R7");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule